// File: doc/BRIEF.md
# RV32I Integer ALU with Packed-Key Decode

This block is the combinational arithmetic and logic unit of a 32-bit RISC-V integer core. It takes one 17-bit operation key and two 32-bit operands. The key joins the instruction's funct7, funct3 and major opcode fields. The second operand is either a register value or an immediate that the decoder has already produced. The block returns the 32-bit result and a flag that marks encodings the unit must not execute. Register-register and register-immediate arithmetic, logic, shift and compare operations are covered.

A control module decodes the key into a small struct of strobes. A datapath module computes every candidate result and picks one of them. It drives the output to zero whenever the operation is not allowed or the opcode belongs to neither supported group. The block has no clock: both outputs settle in the same cycle as the inputs.

Top module: `rv_alu_core`

## Requirements
- R1: The key is packed as key[16:10] = funct7, key[9:7] = funct3 and key[6:0] = opcode. With opcode 0110011 (register group), funct3 000 and funct7 0000000, the result is a + b modulo 2^32.
- R2: With opcode 0110011, funct3 000 and funct7 0100000, the result is a - b modulo 2^32.
- R3: With opcode 0010011 (immediate group), funct3 000 and funct7 0100000, the error output is 1 and the result is 0.
- R4: funct3 010 gives 1 when a < b as two's-complement signed values, and 0 otherwise. Bits 31:1 of the result are 0.
- R5: funct3 011 gives 1 when a < b as unsigned values, and 0 otherwise. Bits 31:1 of the result are 0.
- R6: funct3 001 with funct7 0000000 shifts a left logically. The shift amount is b[4:0], and b[31:5] has no effect.
- R7: funct3 101 shifts a right by b[4:0]. funct7 0000000 gives a logical shift, which fills with zeros. funct7 0100000 gives an arithmetic shift, which fills with a[31].
- R8: funct3 100 gives a XOR b, funct3 110 gives a OR b, and funct3 111 gives a AND b.
- R9: In the immediate group, funct7 has no effect on the result of funct3 000, 010, 011, 100, 110 or 111, except for the R3 case.
- R10: The error output is 1 and the result is 0 in each of these cases:
  - funct3 001 with any funct7 other than 0000000;
  - funct3 101 with any funct7 other than 0000000 or 0100000;
  - in the register group, any other funct3 with any funct7 other than 0000000, except 0100000 with funct3 000.
- R11: For any opcode other than 0110011 or 0010011, the result is 0 and the error output is 0.
- R12: The outputs depend only on the current inputs. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opKey | input | 17 | Operation key: {funct7, funct3, opcode} |
| srcA | input | 32 | First operand (register value) |
| srcB | input | 32 | Second operand (register value or decoded immediate) |
| aluResult | output | 32 | Operation result, 0 when the operation is illegal or unsupported |
| illegalOp | output | 1 | High when the key is an encoding that may not be executed |

## Verification
The block holds no state, so any decode fault shows at the ports in the same cycle as the key that triggers it. A wrong strobe shows up as a wrong result value, or as a mismatch in the error flag, for that one input pattern. Two kinds of fault are the easiest to miss: the wrong shift fill, and a compare that is treated as signed when it should be unsigned. The bench therefore drives operands at the sign boundary and shift amounts with high bits set in b. It also sweeps every funct7 value across the immediate group, so that a funct7 bit that leaks into the decode is caught.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int KEY_W = 17;
  localparam int F7_W  = 7;
  localparam int F3_W  = 3;
  localparam int OP_W  = 7;

  localparam logic [OP_W-1:0] OPC_REG = 7'b0110011;
  localparam logic [OP_W-1:0] OPC_IMM = 7'b0010011;
  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    SEL_ADD, SEL_SUB, SEL_SLL, SEL_SLT, SEL_SLTU,
    SEL_XOR, SEL_SRL, SEL_SRA, SEL_OR, SEL_AND
  } aluSel_e;

  typedef struct packed {
    aluSel_e opSel;
    logic    illegal;
    logic    outEn;
  } aluStrobes_t;
endpackage

// File: rtl/rv_alu_ctrl.sv
module rv_alu_ctrl
  import rv_alu_pkg::*;
(
  input  logic [KEY_W-1:0] opKey,
  output aluStrobes_t      strobes
);
  logic [F7_W-1:0] funct7;
  logic [F3_W-1:0] funct3;
  logic [OP_W-1:0] opcode;
  logic isRegGrp, isImmGrp, badF7;
  aluSel_e selNext;

  assign funct7   = opKey[KEY_W-1 -: F7_W];
  assign funct3   = opKey[OP_W +: F3_W];
  assign opcode   = opKey[OP_W-1:0];
  assign isRegGrp = (opcode == OPC_REG);
  assign isImmGrp = (opcode == OPC_IMM);

  always_comb begin
    selNext = SEL_ADD;
    badF7   = 1'b0;
    unique case (funct3)
      3'b000: begin
        if (isRegGrp) begin
          if (funct7 == F7_ALT)       selNext = SEL_SUB;
          else if (funct7 != F7_BASE) badF7   = 1'b1;
        end else if (funct7 == F7_ALT) begin
          badF7 = 1'b1;
        end
      end
      3'b001: begin
        selNext = SEL_SLL;
        badF7   = (funct7 != F7_BASE);
      end
      3'b101: begin
        if (funct7 == F7_ALT)       selNext = SEL_SRA;
        else                        selNext = SEL_SRL;
        badF7 = (funct7 != F7_BASE) && (funct7 != F7_ALT);
      end
      3'b010: begin selNext = SEL_SLT;  badF7 = isRegGrp && (funct7 != F7_BASE); end
      3'b011: begin selNext = SEL_SLTU; badF7 = isRegGrp && (funct7 != F7_BASE); end
      3'b100: begin selNext = SEL_XOR;  badF7 = isRegGrp && (funct7 != F7_BASE); end
      3'b110: begin selNext = SEL_OR;   badF7 = isRegGrp && (funct7 != F7_BASE); end
      default: begin selNext = SEL_AND; badF7 = isRegGrp && (funct7 != F7_BASE); end
    endcase
  end

  always_comb begin
    strobes.opSel   = selNext;
    strobes.illegal = (isRegGrp || isImmGrp) && badF7;
    strobes.outEn   = (isRegGrp || isImmGrp) && !badF7;
  end
endmodule

// File: rtl/rv_alu_dp.sv
module rv_alu_dp
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aluStrobes_t     strobes,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] aluResult
);
  localparam int SHAMT_W = $clog2(XLEN);

  logic [SHAMT_W-1:0] shAmt;
  logic [XLEN-1:0] sumVal, diffVal, sllVal, srlVal, sraVal;
  logic lessSigned, lessUnsigned;
  logic [XLEN-1:0] picked;

  assign shAmt        = srcB[SHAMT_W-1:0];
  assign sumVal       = srcA + srcB;
  assign diffVal      = srcA - srcB;
  assign sllVal       = srcA << shAmt;
  assign srlVal       = srcA >> shAmt;
  assign sraVal       = $unsigned($signed(srcA) >>> shAmt);
  assign lessSigned   = $signed(srcA) < $signed(srcB);
  assign lessUnsigned = srcA < srcB;

  always_comb begin
    unique case (strobes.opSel)
      SEL_ADD:  picked = sumVal;
      SEL_SUB:  picked = diffVal;
      SEL_SLL:  picked = sllVal;
      SEL_SLT:  picked = {{(XLEN-1){1'b0}}, lessSigned};
      SEL_SLTU: picked = {{(XLEN-1){1'b0}}, lessUnsigned};
      SEL_XOR:  picked = srcA ^ srcB;
      SEL_SRL:  picked = srlVal;
      SEL_SRA:  picked = sraVal;
      SEL_OR:   picked = srcA | srcB;
      SEL_AND:  picked = srcA & srcB;
      default:  picked = '0;
    endcase
  end

  assign aluResult = strobes.outEn ? picked : '0;
endmodule

// File: rtl/rv_alu_core.sv
module rv_alu_core
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KEY_W-1:0] opKey,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  output logic [XLEN-1:0]  aluResult,
  output logic             illegalOp
);
  aluStrobes_t strobes;

  rv_alu_ctrl u_ctrl (
    .opKey   (opKey),
    .strobes (strobes)
  );

  rv_alu_dp #(.XLEN(XLEN)) u_dp (
    .strobes   (strobes),
    .srcA      (srcA),
    .srcB      (srcB),
    .aluResult (aluResult)
  );

  assign illegalOp = strobes.illegal;
endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk
  import rv_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [KEY_W-1:0] opKey,
  input logic [XLEN-1:0]  srcA,
  input logic [XLEN-1:0]  srcB,
  input logic [XLEN-1:0]  aluResult,
  input logic             illegalOp
);
  logic knownGrp;
  assign knownGrp = (opKey[OP_W-1:0] == OPC_REG) || (opKey[OP_W-1:0] == OPC_IMM);

  always_comb begin
    // R3, R10: an illegal key never leaks a value
    p_zero_on_illegal_r10: assert (!illegalOp || aluResult == '0);
    // R3: subtract-immediate is always flagged
    p_subimm_flag_r3: assert (!(opKey == {F7_ALT, 3'b000, OPC_IMM}) || illegalOp);
    // R11: foreign opcodes give zero and no flag
    p_foreign_quiet_r11: assert (knownGrp || (aluResult == '0 && !illegalOp));
    // R4, R5: compares produce a single bit
    p_cmp_one_bit_r4: assert (!(knownGrp && (opKey[9:8] == 2'b01)) || aluResult[XLEN-1:1] == '0);
    // R1: register add with base funct7 matches a + b
    p_add_sum_r1: assert (!(opKey == {F7_BASE, 3'b000, OPC_REG}) || aluResult == srcA + srcB);
  end
endmodule

bind rv_alu_core rv_alu_chk #(.XLEN(XLEN)) u_chk (
  .opKey     (opKey),
  .srcA      (srcA),
  .srcB      (srcB),
  .aluResult (aluResult),
  .illegalOp (illegalOp)
);

// File: tb/rv_alu_core_test.sv
module rv_alu_core_test;
  localparam logic [6:0] OR_ = 7'b0110011;
  localparam logic [6:0] OI_ = 7'b0010011;
  localparam logic [6:0] FB  = 7'b0000000;
  localparam logic [6:0] FA  = 7'b0100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [16:0] opKey = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [31:0] aluResult;
  logic illegalOp;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rv_alu_core uut (
    .opKey(opKey), .srcA(srcA), .srcB(srcB),
    .aluResult(aluResult), .illegalOp(illegalOp)
  );

  function automatic logic [16:0] mk(logic [6:0] f7, logic [2:0] f3, logic [6:0] op);
    return {f7, f3, op};
  endfunction

  task automatic drive(logic [16:0] k, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opKey = k; srcA = a; srcB = b;
    #1;
  endtask

  task automatic expect_out(string req, logic [31:0] expRes, logic expErr);
    checks++;
    if (aluResult !== expRes || illegalOp !== expErr) begin
      fails++;
      $display("FAIL %s: key=%h a=%h b=%h got res=%h err=%b expected res=%h err=%b",
               req, opKey, srcA, srcB, aluResult, illegalOp, expRes, expErr);
    end
  endtask

  task automatic run(string req, logic [16:0] k, logic [31:0] a, logic [31:0] b,
                     logic [31:0] expRes, logic expErr);
    drive(k, a, b);
    expect_out(req, expRes, expErr);
  endtask

  task automatic t_reset_state;
    run("R11 idle", 17'd0, 32'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_add_sub;
    run("R1 add", mk(FB, 3'b000, OR_), 32'hff, 32'hff00, 32'hffff, 1'b0);
    run("R1 add wrap", mk(FB, 3'b000, OR_), 32'hffffffff, 32'd2, 32'd1, 1'b0);
    run("R2 sub", mk(FA, 3'b000, OR_), 32'hff, 32'hcc, 32'h33, 1'b0);
    run("R2 sub wrap", mk(FA, 3'b000, OR_), 32'd0, 32'd1, 32'hffffffff, 1'b0);
  endtask

  task automatic t_subimm;
    run("R3 subimm", mk(FA, 3'b000, OI_), 32'hff, 32'hcc, 32'd0, 1'b1);
  endtask

  task automatic t_compare;
    run("R4 slt 1<-1", mk(FB, 3'b010, OR_), 32'd1, 32'hffffffff, 32'd0, 1'b0);
    run("R4 slt -10<-1", mk(FB, 3'b010, OR_), 32'hfffffff6, 32'hffffffff, 32'd1, 1'b0);
    run("R4 slt min<max", mk(FB, 3'b010, OR_), 32'h80000000, 32'h7fffffff, 32'd1, 1'b0);
    run("R4 slt equal", mk(FB, 3'b010, OI_), 32'h5, 32'h5, 32'd0, 1'b0);
    run("R5 sltu ff..<1", mk(FB, 3'b011, OR_), 32'hffffffff, 32'd1, 32'd0, 1'b0);
    run("R5 sltu f6<ff", mk(FB, 3'b011, OR_), 32'hfffffff6, 32'hffffffff, 32'd1, 1'b0);
    run("R5 sltu max<min", mk(FB, 3'b011, OR_), 32'h7fffffff, 32'h80000000, 32'd1, 1'b0);
  endtask

  task automatic t_shifts;
    run("R6 sll", mk(FB, 3'b001, OR_), 32'hff, 32'd4, 32'hff0, 1'b0);
    run("R6 sll high b ignored", mk(FB, 3'b001, OR_), 32'hff, 32'hffffffe4, 32'hff0, 1'b0);
    run("R6 slli 31", mk(FB, 3'b001, OI_), 32'h3, 32'd31, 32'h80000000, 1'b0);
    run("R7 srl", mk(FB, 3'b101, OR_), 32'hff00f0f0, 32'd8, 32'h00ff00f0, 1'b0);
    run("R7 sra 8", mk(FA, 3'b101, OR_), 32'hff00f0f0, 32'd8, 32'hffff00f0, 1'b0);
    run("R7 sra 16", mk(FA, 3'b101, OR_), 32'hff00f0f0, 32'd16, 32'hffffff00, 1'b0);
    run("R7 srai 31", mk(FA, 3'b101, OI_), 32'h80000000, 32'h3f, 32'hffffffff, 1'b0);
    run("R7 sra positive", mk(FA, 3'b101, OR_), 32'h70000000, 32'd4, 32'h07000000, 1'b0);
  endtask

  task automatic t_logic;
    run("R8 xor", mk(FB, 3'b100, OR_), 32'hff00f0f0, 32'h00ffff00, 32'hffff0ff0, 1'b0);
    run("R8 or", mk(FB, 3'b110, OR_), 32'h00ff00ff, 32'hff0000ff, 32'hffff00ff, 1'b0);
    run("R8 and", mk(FB, 3'b111, OR_), 32'h00ff00ff, 32'hff0000ff, 32'h000000ff, 1'b0);
  endtask

  task automatic t_imm_funct7;
    logic [31:0] e;
    for (int f = 0; f < 128; f++) begin
      for (int g = 0; g < 8; g++) begin
        if (g == 1 || g == 5) continue;
        if (g == 0 && f == 32) continue;
        case (g)
          0: e = 32'h12345678 + 32'h00000f0f;
          2: e = 32'd0;
          3: e = 32'd0;
          4: e = 32'h12345678 ^ 32'h00000f0f;
          6: e = 32'h12345678 | 32'h00000f0f;
          default: e = 32'h12345678 & 32'h00000f0f;
        endcase
        run("R9 imm funct7 ignored", mk(f[6:0], g[2:0], OI_), 32'h12345678, 32'h00000f0f, e, 1'b0);
      end
    end
  endtask

  task automatic t_bad_funct7;
    run("R10 slli bad f7", mk(7'b0000001, 3'b001, OI_), 32'hff, 32'd1, 32'd0, 1'b1);
    run("R10 sll alt f7", mk(FA, 3'b001, OR_), 32'hff, 32'd1, 32'd0, 1'b1);
    run("R10 srl bad f7", mk(7'b0100001, 3'b101, OR_), 32'hff, 32'd1, 32'd0, 1'b1);
    run("R10 srli bad f7", mk(7'b1000000, 3'b101, OI_), 32'hff, 32'd1, 32'd0, 1'b1);
    run("R10 xor alt f7", mk(FA, 3'b100, OR_), 32'hff, 32'd1, 32'd0, 1'b1);
    run("R10 add odd f7", mk(7'b0000001, 3'b000, OR_), 32'hff, 32'd1, 32'd0, 1'b1);
  endtask

  task automatic t_foreign;
    run("R11 load opcode", mk(FB, 3'b000, 7'b0000011), 32'hff, 32'd1, 32'd0, 1'b0);
    run("R11 near opcode", mk(FA, 3'b000, 7'b0110111), 32'hff, 32'd1, 32'd0, 1'b0);
  endtask

  task automatic t_stateless;
    // R12: same inputs after different history give same outputs
    run("R12 first", mk(FB, 3'b100, OR_), 32'ha5a5a5a5, 32'h0f0f0f0f, 32'haaaaaaaa, 1'b0);
    run("R12 other", mk(FA, 3'b000, OI_), 32'h1, 32'h1, 32'd0, 1'b1);
    run("R12 repeat", mk(FB, 3'b100, OR_), 32'ha5a5a5a5, 32'h0f0f0f0f, 32'haaaaaaaa, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add_sub();
    t_subimm();
    t_compare();
    t_shifts();
    t_logic();
    t_imm_funct7();
    t_bad_funct7();
    t_foreign();
    t_stateless();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule